// File: doc/BRIEF.md
# Micro-frame Periodic List Pointer Generator

This block keeps the host controller's running micro-frame counter and turns it into the memory address of the periodic list slot that serves the current frame. Software loads a 4 KiB-aligned list origin and, while the controller is halted, may preset the counter. Once running, every 125 us strobe advances the counter by one. The block then presents the slot address, a single-cycle fetch pulse, and the micro-frame number within the frame. The list slot changes only once per frame, so one slot address serves eight micro-frames in a row.

The block also orders the work inside each micro-frame. It opens the periodic phase first. It moves to the asynchronous phase when the periodic walker reports completion or periodic work is disabled. Each phase is entered only if its own enable is set. The schedule walkers, the memory port and the bus link sit outside this block and react to the fetch pulse and the phase code.

Top module: `uframe_list_ptr_gen`

## Requirements
- R1: After a synchronous reset, the counter and the list origin are zero, `slot_addr` is 0, `fetch_pulse` is 0, `uframe_no` is 0 and `work_phase` is idle (2'b00).
- R2: A clock edge that samples `uframe_strobe` and `run` both high advances the 13-bit counter by one. The counter wraps from 8191 to 0.
- R3: While `run` is low, `uframe_strobe` has no effect on the counter, the address, the pulse or the phase.
- R4: `cnt_load` copies `cnt_load_val` into the counter only while `run` is low. While `run` is high, the load is ignored.
- R5: `origin_load` keeps bits 31:12 of `origin_val` and drops bits 11:0. `slot_addr` is always {origin[31:12], counter[12:3], 2'b00}, so bits 1:0 are zero.
- R6: `uframe_no` equals counter bits 2:0. `slot_addr` stays the same across the eight micro-frames of one frame unless the origin is reloaded.
- R7: `fetch_pulse` is high for exactly one cycle after each edge at which the counter advances, and is low at all other times.
- R8: On the edge that starts a micro-frame, `work_phase` becomes periodic (2'b01) if `per_enable` is high. Asynchronous work (2'b10) never comes before periodic work in the same micro-frame.
- R9: From the periodic phase, `per_done` or a low `per_enable` moves the phase to asynchronous (2'b10) if `async_enable` is high, and to idle otherwise. Asynchronous falls back to idle when `async_enable` goes low.
- R10: If `per_enable` is low when a micro-frame starts, the phase goes straight to asynchronous when `async_enable` is high, and to idle otherwise.
- R11: One cycle after `run` is sampled low, `work_phase` is idle. A new micro-frame strobe restarts the sequence even if the periodic phase is still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run (1) / halt (0) |
| uframe_strobe | input | 1 | One-cycle 125 us micro-frame tick |
| per_enable | input | 1 | Periodic schedule enable |
| async_enable | input | 1 | Asynchronous schedule enable |
| per_done | input | 1 | Periodic walker finished this micro-frame |
| origin_load | input | 1 | Write strobe for the list origin |
| origin_val | input | 32 | List origin write data (bits 11:0 dropped) |
| cnt_load | input | 1 | Write strobe for the micro-frame counter |
| cnt_load_val | input | 13 | Counter write data |
| slot_addr | output | 32 | Address of the current periodic list slot |
| fetch_pulse | output | 1 | One-cycle start-of-micro-frame pulse |
| uframe_no | output | 3 | Micro-frame number inside the frame |
| work_phase | output | 2 | 00 idle, 01 periodic, 10 asynchronous |

## Verification
The in-line assertions assume that micro-frame strobes never come on two consecutive cycles, since real strobes are thousands of cycles apart. The stimulus therefore leaves at least one quiet cycle after every strobe. They also assume that `per_done` is a one-cycle pulse from the walker. The stimulus raises it only between strobes and only for one cycle. The enables are toggled at arbitrary points, including in the middle of a phase. Counter presets are issued both while halted and while running, so that the gating on loads is exercised in both states.

// File: rtl/ulp_pkg.sv
package ulp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_PER   = 2'b01,
    PH_ASYNC = 2'b10
  } phase_e;
endpackage

// File: rtl/ulp_counter.sv
module ulp_counter #(
  parameter int ENTRY_W = 10,
  parameter int USUB_W  = 3,
  localparam int IDX_W  = ENTRY_W + USUB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               strobe,
  input  logic               load,
  input  logic [IDX_W-1:0]   load_val,
  output logic               advance,
  output logic [ENTRY_W-1:0] entry_next,
  output logic [USUB_W-1:0]  uframe_q
);
  logic [IDX_W-1:0] idx_q, idx_d;

  assign advance = run & strobe;

  always_comb begin
    idx_d = idx_q;
    if (advance)
      idx_d = idx_q + 1'b1;
    else if (!run && load)
      idx_d = load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

  assign entry_next = idx_d[IDX_W-1:USUB_W];
  assign uframe_q   = idx_q[USUB_W-1:0];

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && strobe) |=> (idx_q == $past(idx_q) + 1'b1)); // R2
  AST_IDX_FROZEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(idx_q)); // R3
  AST_IDX_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (run && !strobe) |=> $stable(idx_q)); // R4
endmodule

// File: rtl/ulp_addr_former.sv
module ulp_addr_former #(
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 10,
  localparam int LOW_W  = ENTRY_W + 2,
  localparam int ORG_W  = ADDR_W - LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               origin_load,
  input  logic [ORG_W-1:0]   origin_hi,
  input  logic [ENTRY_W-1:0] entry_next,
  output logic [ADDR_W-1:0]  addr_q
);
  logic [ORG_W-1:0] org_q, org_d;

  assign org_d = origin_load ? origin_hi : org_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      org_q  <= '0;
      addr_q <= '0;
    end else begin
      org_q  <= org_d;
      addr_q <= {org_d, entry_next, 2'b00};
    end
  end

  AST_ORIGIN_HELD: assert property (@(posedge clk) disable iff (rst)
    !origin_load |=> (addr_q[ADDR_W-1:LOW_W] == $past(addr_q[ADDR_W-1:LOW_W]))); // R5
endmodule

// File: rtl/ulp_phase_seq.sv
module ulp_phase_seq
  import ulp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   advance,
  input  logic   per_enable,
  input  logic   async_enable,
  input  logic   per_done,
  output phase_e phase_q,
  output logic   pulse_q
);
  phase_e phase_d, after_per;

  assign after_per = async_enable ? PH_ASYNC : PH_IDLE;

  always_comb begin
    phase_d = phase_q;
    if (!run)
      phase_d = PH_IDLE;
    else if (advance)
      phase_d = per_enable ? PH_PER : after_per;
    else begin
      unique case (phase_q)
        PH_PER:   if (per_done || !per_enable) phase_d = after_per;
        PH_ASYNC: if (!async_enable) phase_d = PH_IDLE;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pulse_q <= advance;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R7
  AST_PER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (advance && per_enable) |=> (phase_q == PH_PER)); // R8
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == PH_IDLE)); // R11
  AST_NO_ASYNC_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!async_enable && !advance) |=> (phase_q != PH_ASYNC)); // R9
endmodule

// File: rtl/uframe_list_ptr_gen.sv
module uframe_list_ptr_gen
  import ulp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 10,
  parameter int USUB_W  = 3,
  localparam int IDX_W  = ENTRY_W + USUB_W,
  localparam int LOW_W  = ENTRY_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              uframe_strobe,
  input  logic              per_enable,
  input  logic              async_enable,
  input  logic              per_done,
  input  logic              origin_load,
  input  logic [ADDR_W-1:0] origin_val,
  input  logic              cnt_load,
  input  logic [IDX_W-1:0]  cnt_load_val,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              fetch_pulse,
  output logic [USUB_W-1:0] uframe_no,
  output logic [1:0]        work_phase
);
  logic               advance;
  logic [ENTRY_W-1:0] entry_next;
  phase_e             phase_q;
  logic               unused_origin_low;

  assign unused_origin_low = ^origin_val[LOW_W-1:0];

  ulp_counter #(.ENTRY_W(ENTRY_W), .USUB_W(USUB_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .strobe(uframe_strobe),
    .load(cnt_load), .load_val(cnt_load_val), .advance(advance),
    .entry_next(entry_next), .uframe_q(uframe_no)
  );

  ulp_addr_former #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_addr (
    .clk(clk), .rst(rst), .origin_load(origin_load),
    .origin_hi(origin_val[ADDR_W-1:LOW_W]), .entry_next(entry_next),
    .addr_q(slot_addr)
  );

  ulp_phase_seq u_seq (
    .clk(clk), .rst(rst), .run(run), .advance(advance),
    .per_enable(per_enable), .async_enable(async_enable),
    .per_done(per_done), .phase_q(phase_q), .pulse_q(fetch_pulse)
  );

  assign work_phase = phase_q;

  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (fetch_pulse && uframe_no != '0 && !$past(origin_load)) |-> $stable(slot_addr)); // R6
  AST_PULSE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    !(run && uframe_strobe) |=> !fetch_pulse); // R3
endmodule

// File: tb/tb_uframe_list_ptr_gen.sv
module tb_uframe_list_ptr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0, uframe_strobe = 1'b0, per_enable = 1'b0;
  logic        async_enable = 1'b0, per_done = 1'b0;
  logic        origin_load = 1'b0, cnt_load = 1'b0;
  logic [31:0] origin_val = '0;
  logic [12:0] cnt_load_val = '0;
  logic [31:0] slot_addr;
  logic        fetch_pulse;
  logic [2:0]  uframe_no;
  logic [1:0]  work_phase;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_idx = 0;
  logic [31:0] m_org = '0;
  bit          m_pulse = 0;
  int          m_phase = 0;

  always #4 clk = ~clk;

  uframe_list_ptr_gen dut (
    .clk(clk), .rst(rst), .run(run), .uframe_strobe(uframe_strobe),
    .per_enable(per_enable), .async_enable(async_enable), .per_done(per_done),
    .origin_load(origin_load), .origin_val(origin_val), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .slot_addr(slot_addr), .fetch_pulse(fetch_pulse),
    .uframe_no(uframe_no), .work_phase(work_phase)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_org = '0; m_pulse = 0; m_phase = 0;
    end else begin
      if (!run) m_phase = 0;
      else if (uframe_strobe) m_phase = per_enable ? 1 : (async_enable ? 2 : 0);
      else if (m_phase == 1 && (per_done || !per_enable)) m_phase = async_enable ? 2 : 0;
      else if (m_phase == 2 && !async_enable) m_phase = 0;
      m_pulse = run && uframe_strobe;
      if (run && uframe_strobe) m_idx = (m_idx + 1) % 8192;
      else if (!run && cnt_load) m_idx = int'(cnt_load_val);
      if (origin_load) m_org = origin_val & 32'hFFFF_F000;
    end
  end

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cur_req, "slot_addr(R5)", slot_addr, m_org | (32'(m_idx >> 3) << 2));
    chk(cur_req, "uframe_no(R6)", {29'd0, uframe_no}, 32'(m_idx & 7));
    chk(cur_req, "fetch_pulse(R7)", {31'd0, fetch_pulse}, {31'd0, m_pulse});
    chk(cur_req, "work_phase(R8)", {30'd0, work_phase}, 32'(m_phase));
  endtask

  task automatic frame(int gap, int done_at);
    uframe_strobe = 1'b1; step(); uframe_strobe = 1'b0;
    for (int i = 0; i < gap; i++) begin
      per_done = (i == done_at);
      step();
    end
    per_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    cur_req = "R1"; step();
    chk("R1", "reset addr", slot_addr, 32'h0);
    chk("R1", "reset phase", {30'd0, work_phase}, 32'h0);

    // halted: origin and preset, strobes ignored
    cur_req = "R5"; origin_load = 1'b1; origin_val = 32'h1234_5ABC; step();
    origin_load = 1'b0;
    cur_req = "R4"; cnt_load = 1'b1; cnt_load_val = 13'd8190; step();
    cnt_load = 1'b0; step();
    chk("R5", "origin+preset addr", slot_addr, 32'h1234_5FFC);
    chk("R4", "preset uframe", {29'd0, uframe_no}, 32'd6);
    cur_req = "R3"; per_enable = 1'b1;
    for (int i = 0; i < 3; i++) frame(2, -1);
    chk("R3", "halted strobe pulse", {31'd0, fetch_pulse}, 32'd0);

    // run across wrap
    cur_req = "R2"; run = 1'b1; async_enable = 1'b1; step();
    frame(3, 1); frame(3, 1);
    chk("R2", "wrap addr", slot_addr, 32'h1234_5000);
    chk("R2", "wrap uframe", {29'd0, uframe_no}, 32'd0);

    // load while running ignored
    cur_req = "R4"; cnt_load = 1'b1; cnt_load_val = 13'd77; step(); step();
    cnt_load = 1'b0;
    chk("R4", "running load ignored", {29'd0, uframe_no}, 32'd0);

    // full frames, slot held
    cur_req = "R6";
    for (int i = 0; i < 20; i++) frame(4, i % 3);
    cur_req = "R9"; async_enable = 1'b0;
    for (int i = 0; i < 4; i++) frame(3, 0);
    async_enable = 1'b1; frame(4, 1); step(); async_enable = 1'b0; step(); async_enable = 1'b1;
    cur_req = "R10"; per_enable = 1'b0;
    for (int i = 0; i < 4; i++) frame(2, -1);
    async_enable = 1'b0; frame(2, -1);
    chk("R10", "skip to idle", {30'd0, work_phase}, 32'd0);
    async_enable = 1'b1; per_enable = 1'b1;

    // strobe while periodic still open, then halt
    cur_req = "R11";
    frame(1, -1); frame(2, -1);
    run = 1'b0; step(); step();
    chk("R11", "halt idle", {30'd0, work_phase}, 32'd0);
    run = 1'b1; origin_load = 1'b1; origin_val = 32'hFFFF_FFFF; step(); origin_load = 1'b0;
    cur_req = "R7";
    for (int i = 0; i < 10; i++) frame(1 + (i % 3), 0);
    rst = 1'b1; cur_req = "R1"; step(); step(); rst = 1'b0; step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule